// File: doc/BRIEF.md
# Four-Way Set-Associative Data Cache Controller

This block sits between a 32-bit processor load/store port and a word-serial memory port. It holds 8 KB of data as 128 sets of four 16-byte lines. Each line has a tag, a valid flag and a modified flag. A request's word address is split into tag, set index and word-in-line. The four tags of the selected set are compared in parallel. A hit is answered from the stored line. A miss fetches the whole line from memory.

A mode input selects the write policy at run time. In write-back mode, stores stay in the cache and mark the line modified. A modified line is copied back to memory before it is replaced. In write-through mode, every store is forwarded to memory. Stores that miss do not claim a line in this mode.

Replacement follows a per-set recency order. Two control inputs can pin ways 2 and 3 so that they are never replaced. Lines already in those ways keep serving hits.

Top module: `opcache_ctrl`

## Requirements
- R1: The processor presents address bits [31:2]. Bits [3:2] pick the word in a line, bits [10:4] pick one of 128 sets, and bits [31:11] form the 21-bit tag. Two addresses with different set bits never share a line.
- R2: A hit is answered with `cpu_ready` high for one cycle, in the cycle right after the one where `cpu_req` was sampled, with no memory traffic. A read hit returns the stored word on `cpu_rdata`.
- R3: A read miss reads the four words of the line from memory at line offsets 0, 4, 8 and 12, in that order. It then raises `cpu_ready` with the requested word. Later accesses to any word of that line hit.
- R4: After reset the recency order of every set, from most to least recent, is way 0, 1, 2, 3. Every hit and every fill makes the accessed way the most recent. A miss replaces the least recent way that is not pinned.
- R5: While `lock_way2` or `lock_way3` is high, that way (2 or 3) is never chosen for replacement. Hits to a pinned way still return data and still refresh its recency.
- R6: With `wb_mode` = 1, a write hit updates the cached word, marks the line modified and causes no memory traffic.
- R7: With `wb_mode` = 1, replacing a modified line first writes its four words to memory at the old line address, in word order 0 to 3, and then reads the new line.
- R8: With `wb_mode` = 1, a write miss fills the line first and then merges the written word into it. It marks the line modified and writes nothing to memory.
- R9: With `wb_mode` = 0, every write causes exactly one memory write of that word, and a write hit also updates the cached word. A write miss allocates no line and leaves recency unchanged. No line is ever marked modified.
- R10: After reset every line is invalid and `cpu_ready` and `mem_req` are low.
- R11: `mem_req` stays high with a stable address and write data until `mem_ack`. Each `mem_ack` completes exactly one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_mode | input | 1 | 1 = write-back, 0 = write-through |
| lock_way2 | input | 1 | Exclude way 2 from replacement |
| lock_way3 | input | 1 | Exclude way 3 from replacement |
| cpu_req | input | 1 | One-cycle request pulse, accepted while idle |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_waddr | input | 30 | Word address, byte address bits [31:2] |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Completes one word transfer |

## Verification
The bench fills one set to capacity, refreshes its oldest line and then forces a miss. If the recency update were skipped on hits, the refreshed line would be evicted, and the next access to it would show fill traffic where none is expected. With ways 2 and 3 pinned, it forces misses whose true oldest line sits in a pinned way; a design that ignored the pins would lose that line. Dirty eviction is checked word by word, so a copy-back at the new tag's address, with stale data, or in the wrong order is caught. Lines stored in write-through mode are later evicted in write-back mode, so a design that marked them modified would emit an unexpected copy-back. A write-through miss is followed by a read of the same word, which must miss; a design that allocated on that write would return the word without fetching.

// File: rtl/opc_pkg.sv
package opc_pkg;
    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_RESP,
        ST_WT
    } opc_state_e;
endpackage

// File: rtl/opc_lru.sv
module opc_lru #(
    parameter int WAYS = 4,
    parameter int SETS = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(SETS)-1:0]  q_set,
    input  logic [WAYS-1:0]          lock_mask,
    output logic [$clog2(WAYS)-1:0]  victim,
    input  logic                     upd_en,
    input  logic [$clog2(SETS)-1:0]  upd_set,
    input  logic [$clog2(WAYS)-1:0]  upd_way
);
    localparam int WAY_W = $clog2(WAYS);
    localparam int IDX_W = $clog2(SETS);

    // rank 0 = most recent, WAYS-1 = least recent
    logic [WAY_W-1:0] rank_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    rank_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (upd_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == upd_way) begin
                    rank_q[upd_set][w] <= '0;
                end else if (rank_q[upd_set][w] < rank_q[upd_set][upd_way]) begin
                    rank_q[upd_set][w] <= rank_q[upd_set][w] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        logic             found;
        logic [WAY_W-1:0] best;
        found  = 1'b0;
        best   = '0;
        victim = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!lock_mask[w] && (!found || rank_q[q_set][w] > best)) begin
                found  = 1'b1;
                best   = rank_q[q_set][w];
                victim = WAY_W'(w);
            end
        end
    end

    logic [WAYS-1:0] rank_seen;
    always_comb begin
        rank_seen = '0;
        for (int w = 0; w < WAYS; w++) begin
            rank_seen[rank_q[q_set][w]] = 1'b1;
        end
    end

    // R4: each set keeps a full ordering of its ways
    a_r4_rank_perm: assert property (@(posedge clk) disable iff (!rst_n)
        rank_seen == {WAYS{1'b1}});

    // R5: a pinned way is never offered for replacement
    a_r5_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_mask[victim]);

    logic unused_idx;
    assign unused_idx = ^IDX_W;
endmodule

// File: rtl/opc_tag.sv
module opc_tag #(
    parameter int WAYS  = 4,
    parameter int SETS  = 128,
    parameter int TAG_W = 21
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(SETS)-1:0]  lk_set,
    input  logic [TAG_W-1:0]         lk_tag,
    output logic                     hit,
    output logic [$clog2(WAYS)-1:0]  hit_way,
    input  logic [$clog2(SETS)-1:0]  vr_set,
    input  logic [$clog2(WAYS)-1:0]  vr_way,
    output logic                     vr_valid,
    output logic                     vr_dirty,
    output logic [TAG_W-1:0]         vr_tag,
    input  logic                     wr_en,
    input  logic [$clog2(SETS)-1:0]  wr_set,
    input  logic [$clog2(WAYS)-1:0]  wr_way,
    input  logic [TAG_W-1:0]         wr_tag,
    input  logic                     wr_valid,
    input  logic                     wr_dirty
);
    localparam int WAY_W = $clog2(WAYS);

    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic             valid_q [SETS][WAYS];
    logic             dirty_q [SETS][WAYS];
    logic [WAYS-1:0]  match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    valid_q[s][w] <= 1'b0;
                    dirty_q[s][w] <= 1'b0;
                end
            end
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= wr_valid;
            dirty_q[wr_set][wr_way] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way] <= wr_tag;
        end
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = valid_q[lk_set][g] && (tag_q[lk_set][g] == lk_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end
    assign hit = |match;

    assign vr_valid = valid_q[vr_set][vr_way];
    assign vr_dirty = dirty_q[vr_set][vr_way];
    assign vr_tag   = tag_q[vr_set][vr_way];

    // R3: a line is installed only on a miss, so a tag lives in at most one way
    a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/opc_data.sv
module opc_data #(
    parameter int WAYS       = 4,
    parameter int SETS       = 128,
    parameter int LINE_WORDS = 4,
    parameter int WORD_W     = 32
) (
    input  logic                          clk,
    input  logic [$clog2(SETS)-1:0]       rd_set,
    input  logic [$clog2(WAYS)-1:0]       rd_way,
    input  logic [$clog2(LINE_WORDS)-1:0] rd_word,
    output logic [WORD_W-1:0]             rd_data,
    input  logic                          wr_en,
    input  logic [$clog2(SETS)-1:0]       wr_set,
    input  logic [$clog2(WAYS)-1:0]       wr_way,
    input  logic [$clog2(LINE_WORDS)-1:0] wr_word,
    input  logic [WORD_W-1:0]             wr_data
);
    localparam int PTR_W = $clog2(SETS) + $clog2(WAYS) + $clog2(LINE_WORDS);
    localparam int DEPTH = SETS * WAYS * LINE_WORDS;

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  rd_ptr;
    logic [PTR_W-1:0]  wr_ptr;

    assign rd_ptr = {rd_set, rd_way, rd_word};
    assign wr_ptr = {wr_set, wr_way, wr_word};

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_ptr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_ptr];
endmodule

// File: rtl/opcache_ctrl.sv
module opcache_ctrl
    import opc_pkg::*;
#(
    parameter int WAYS       = 4,
    parameter int SETS       = 128,
    parameter int LINE_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_mode,
    input  logic              lock_way2,
    input  logic              lock_way3,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:2] cpu_waddr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int WAY_W = $clog2(WAYS);
    localparam int IDX_W = $clog2(SETS);
    localparam int WRD_W = $clog2(LINE_WORDS);
    localparam int TAG_W = ADDR_W - 2 - WRD_W - IDX_W;
    localparam logic [WRD_W-1:0] LAST_WORD = WRD_W'(LINE_WORDS - 1);

    typedef struct packed {
        opc_state_e        state;
        logic [ADDR_W-1:2] waddr;
        logic              we;
        logic [WORD_W-1:0] wdata;
        logic [WAY_W-1:0]  way;
        logic [WRD_W-1:0]  cnt;
        logic              ready;
        logic [WORD_W-1:0] rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // address fields of the incoming request and of the held request
    logic [IDX_W-1:0] c_set, s_set;
    logic [TAG_W-1:0] c_tag, s_tag;
    logic [WRD_W-1:0] c_word, s_word;
    assign c_word = cpu_waddr[2 +: WRD_W];
    assign c_set  = cpu_waddr[2 + WRD_W +: IDX_W];
    assign c_tag  = cpu_waddr[ADDR_W-1 -: TAG_W];
    assign s_word = ctl_q.waddr[2 +: WRD_W];
    assign s_set  = ctl_q.waddr[2 + WRD_W +: IDX_W];
    assign s_tag  = ctl_q.waddr[ADDR_W-1 -: TAG_W];

    logic idle;
    assign idle = (ctl_q.state == ST_IDLE);

    logic [WAYS-1:0] lock_mask;
    always_comb begin
        lock_mask    = '0;
        lock_mask[2] = lock_way2;
        lock_mask[3] = lock_way3;
    end

    // sub-block wiring
    logic             hit;
    logic [WAY_W-1:0] hit_way, victim;
    logic             vr_valid, vr_dirty;
    logic [TAG_W-1:0] vr_tag;
    logic [WAY_W-1:0] vr_way;
    logic [IDX_W-1:0] vr_set;
    logic             lru_en;
    logic [IDX_W-1:0] lru_set;
    logic [WAY_W-1:0] lru_way;
    logic             twr_en, twr_valid, twr_dirty;
    logic [IDX_W-1:0] twr_set;
    logic [WAY_W-1:0] twr_way;
    logic [TAG_W-1:0] twr_tag;
    logic [IDX_W-1:0] drd_set;
    logic [WAY_W-1:0] drd_way;
    logic [WRD_W-1:0] drd_word;
    logic [WORD_W-1:0] drd_data;
    logic             dwr_en;
    logic [IDX_W-1:0] dwr_set;
    logic [WAY_W-1:0] dwr_way;
    logic [WRD_W-1:0] dwr_word;
    logic [WORD_W-1:0] dwr_data;

    assign vr_set   = idle ? c_set : s_set;
    assign vr_way   = idle ? victim : ctl_q.way;
    assign drd_set  = idle ? c_set : s_set;
    assign drd_way  = idle ? hit_way : ctl_q.way;
    assign drd_word = idle ? c_word : ((ctl_q.state == ST_EVICT) ? ctl_q.cnt : s_word);

    opc_tag #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tag (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_set   (c_set),
        .lk_tag   (c_tag),
        .hit      (hit),
        .hit_way  (hit_way),
        .vr_set   (vr_set),
        .vr_way   (vr_way),
        .vr_valid (vr_valid),
        .vr_dirty (vr_dirty),
        .vr_tag   (vr_tag),
        .wr_en    (twr_en),
        .wr_set   (twr_set),
        .wr_way   (twr_way),
        .wr_tag   (twr_tag),
        .wr_valid (twr_valid),
        .wr_dirty (twr_dirty)
    );

    opc_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_set     (c_set),
        .lock_mask (lock_mask),
        .victim    (victim),
        .upd_en    (lru_en),
        .upd_set   (lru_set),
        .upd_way   (lru_way)
    );

    opc_data #(.WAYS(WAYS), .SETS(SETS), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)) u_data (
        .clk     (clk),
        .rd_set  (drd_set),
        .rd_way  (drd_way),
        .rd_word (drd_word),
        .rd_data (drd_data),
        .wr_en   (dwr_en),
        .wr_set  (dwr_set),
        .wr_way  (dwr_way),
        .wr_word (dwr_word),
        .wr_data (dwr_data)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.ready = 1'b0;

        lru_en  = 1'b0;
        lru_set = s_set;
        lru_way = ctl_q.way;

        twr_en    = 1'b0;
        twr_set   = s_set;
        twr_way   = ctl_q.way;
        twr_tag   = s_tag;
        twr_valid = 1'b1;
        twr_dirty = 1'b0;

        dwr_en   = 1'b0;
        dwr_set  = s_set;
        dwr_way  = ctl_q.way;
        dwr_word = s_word;
        dwr_data = ctl_q.wdata;

        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {ctl_q.waddr, 2'b00};
        mem_wdata = ctl_q.wdata;

        unique case (ctl_q.state)
            ST_IDLE: begin
                if (cpu_req) begin
                    ctl_d.waddr = cpu_waddr;
                    ctl_d.we    = cpu_we;
                    ctl_d.wdata = cpu_wdata;
                    ctl_d.cnt   = '0;
                    if (hit) begin
                        ctl_d.way = hit_way;
                        lru_en    = 1'b1;
                        lru_set   = c_set;
                        lru_way   = hit_way;
                        if (!cpu_we) begin
                            ctl_d.rdata = drd_data;
                            ctl_d.ready = 1'b1;
                        end else begin
                            dwr_en   = 1'b1;
                            dwr_set  = c_set;
                            dwr_way  = hit_way;
                            dwr_word = c_word;
                            dwr_data = cpu_wdata;
                            if (wb_mode) begin
                                twr_en    = 1'b1;
                                twr_set   = c_set;
                                twr_way   = hit_way;
                                twr_tag   = c_tag;
                                twr_dirty = 1'b1;
                                ctl_d.ready = 1'b1;
                            end else begin
                                ctl_d.state = ST_WT;
                            end
                        end
                    end else if (cpu_we && !wb_mode) begin
                        ctl_d.state = ST_WT;
                    end else begin
                        ctl_d.way   = victim;
                        ctl_d.state = (wb_mode && vr_valid && vr_dirty) ? ST_EVICT : ST_FILL;
                    end
                end
            end

            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {vr_tag, s_set, ctl_q.cnt, 2'b00};
                mem_wdata = drd_data;
                if (mem_ack) begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == LAST_WORD) begin
                        ctl_d.state = ST_FILL;
                    end
                end
            end

            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {s_tag, s_set, ctl_q.cnt, 2'b00};
                if (mem_ack) begin
                    dwr_en    = 1'b1;
                    dwr_word  = ctl_q.cnt;
                    dwr_data  = mem_rdata;
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == LAST_WORD) begin
                        twr_en      = 1'b1;
                        ctl_d.state = ST_RESP;
                    end
                end
            end

            ST_RESP: begin
                lru_en      = 1'b1;
                ctl_d.ready = 1'b1;
                ctl_d.state = ST_IDLE;
                if (ctl_q.we) begin
                    dwr_en    = 1'b1;
                    twr_en    = 1'b1;
                    twr_dirty = 1'b1;
                end else begin
                    ctl_d.rdata = drd_data;
                end
            end

            ST_WT: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    ctl_d.ready = 1'b1;
                    ctl_d.state = ST_IDLE;
                end
            end

            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cpu_ready = ctl_q.ready;
    assign cpu_rdata = ctl_q.rdata;

    // R2: a hit that needs no memory write answers on the next cycle
    a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && cpu_req && hit && !(cpu_we && !wb_mode)) |=> cpu_ready);

    // R3: fill words are fetched at consecutive word addresses
    a_r3_fill_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_FILL && mem_ack && ctl_q.cnt != LAST_WORD)
        |=> (mem_addr == $past(mem_addr) + 32'd4));

    // R11: an outstanding memory request keeps its address until acknowledged
    a_r11_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: tb/opcache_ctrl_bench.sv
module opcache_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wb_mode = 1'b1;
    logic        lock_way2 = 1'b0;
    logic        lock_way3 = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:2] cpu_waddr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    always #2.5 clk = ~clk;

    opcache_ctrl u_opcache_ctrl (
        .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode),
        .lock_way2(lock_way2), .lock_way3(lock_way3),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_waddr(cpu_waddr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int checks = 0;
    int fails  = 0;

    typedef struct { bit chk; logic [31:0] d; string r; } sb_t;
    typedef struct { bit we; logic [31:0] a; logic [31:0] d; } tr_t;
    sb_t sb_q [$];
    tr_t tr_q [$];
    tr_t ex_q [$];

    logic [31:0] mm   [logic [31:0]];
    logic [31:0] view [logic [31:0]];

    function automatic logic [31:0] init_val(logic [31:0] a);
        return (a * 32'h0100_0193) ^ 32'hC0DE_0000;
    endfunction
    function automatic logic [31:0] mm_rd(logic [31:0] a);
        return mm.exists(a) ? mm[a] : init_val(a);
    endfunction
    function automatic logic [31:0] view_rd(logic [31:0] a);
        return view.exists(a) ? view[a] : init_val(a);
    endfunction
    function automatic logic [31:0] A(int t, int s, int w);
        return (32'(t) << 11) | (32'(s) << 4) | (32'(w) << 2);
    endfunction

    // memory model, two negedges per word; R11 address hold check
    int          wait_c = 0;
    logic [31:0] held_a;
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wait_c == 0) begin
                held_a = mem_addr;
                wait_c = 1;
            end else begin
                wait_c = 0;
                checks++;
                if (mem_addr !== held_a) begin
                    fails++;
                    $display("FAIL R11 address moved: actual %h expected %h", mem_addr, held_a);
                end
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mm[mem_addr] = mem_wdata;
                    tr_q.push_back('{1'b1, mem_addr, mem_wdata});
                end else begin
                    mem_rdata <= mm_rd(mem_addr);
                    tr_q.push_back('{1'b0, mem_addr, 32'h0});
                end
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && cpu_ready) begin
            if (sb_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R2 unexpected ready: actual 1 expected 0");
            end else begin
                sb_t it;
                it = sb_q.pop_front();
                if (it.chk) begin
                    checks++;
                    if (cpu_rdata !== it.d) begin
                        fails++;
                        $display("FAIL %s read data: actual %h expected %h", it.r, cpu_rdata, it.d);
                    end
                end
            end
        end
    end

    task automatic exp_fill(logic [31:0] base);
        for (int i = 0; i < 4; i++) ex_q.push_back('{1'b0, base + 32'(4*i), 32'h0});
    endtask
    task automatic exp_evict(logic [31:0] base);
        for (int i = 0; i < 4; i++)
            ex_q.push_back('{1'b1, base + 32'(4*i), view_rd(base + 32'(4*i))});
    endtask
    task automatic exp_wt(logic [31:0] a, logic [31:0] d);
        ex_q.push_back('{1'b1, a, d});
    endtask

    task automatic compare_log(string r);
        bit bad;
        bad = (tr_q.size() != ex_q.size());
        if (!bad) begin
            foreach (tr_q[i]) begin
                if (tr_q[i].we != ex_q[i].we || tr_q[i].a != ex_q[i].a ||
                    (tr_q[i].we && tr_q[i].d != ex_q[i].d)) bad = 1'b1;
            end
        end
        checks++;
        if (bad) begin
            fails++;
            $display("FAIL %s memory traffic: actual %0d words (first %h) expected %0d words (first %h)",
                     r, tr_q.size(), (tr_q.size() > 0) ? tr_q[0].a : 32'h0,
                     ex_q.size(), (ex_q.size() > 0) ? ex_q[0].a : 32'h0);
        end
        tr_q.delete();
        ex_q.delete();
    endtask

    // driver: pushes the expected result, issues the request, waits for ready
    task automatic op(bit we, logic [31:0] a, logic [31:0] wd, string r, bit is_hit);
        sb_t it;
        int  lat;
        it.chk = !we;
        it.d   = we ? 32'h0 : view_rd(a);
        it.r   = r;
        sb_q.push_back(it);
        if (we) view[a] = wd;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_waddr = a[31:2]; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        lat = 1;
        while (!cpu_ready) begin
            @(negedge clk);
            lat++;
        end
        @(negedge clk);
        compare_log(r);
        if (is_hit) begin
            checks++;
            if (lat != 1) begin
                fails++;
                $display("FAIL %s hit latency: actual %0d expected 1", r, lat);
            end
        end
    endtask

    task automatic rd_miss(int t, int s, int w, string r);
        exp_fill(A(t, s, 0));
        op(1'b0, A(t, s, w), 32'h0, r, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (cpu_ready !== 1'b0 || mem_req !== 1'b0) begin
            fails++;
            $display("FAIL R10 reset outputs: actual %b%b expected 00", cpu_ready, mem_req);
        end

        // R3 read miss fill, R2 hit, R1 field split
        rd_miss(1, 5, 2, "R3");
        op(1'b0, A(1, 5, 0), 32'h0, "R2", 1'b1);
        op(1'b0, A(1, 5, 3), 32'h0, "R1", 1'b1);
        rd_miss(1, 6, 1, "R1");

        // R4 recency: fill set 5, refresh tag 1, miss must evict tag 2
        rd_miss(2, 5, 0, "R4");
        rd_miss(3, 5, 0, "R4");
        rd_miss(4, 5, 0, "R4");
        op(1'b0, A(1, 5, 1), 32'h0, "R4", 1'b1);
        rd_miss(5, 5, 0, "R4");
        op(1'b0, A(1, 5, 2), 32'h0, "R4", 1'b1);
        rd_miss(2, 5, 3, "R4");

        // R5 pinned ways 2 and 3 hold tags 2 and 1 of set 9
        for (int t = 1; t <= 4; t++) rd_miss(t, 9, 0, "R5");
        lock_way2 = 1'b1; lock_way3 = 1'b1;
        rd_miss(5, 9, 0, "R5");
        op(1'b0, A(1, 9, 1), 32'h0, "R5", 1'b1);
        rd_miss(6, 9, 0, "R5");
        op(1'b0, A(2, 9, 0), 32'h0, "R5", 1'b1);
        op(1'b0, A(5, 9, 0), 32'h0, "R5", 1'b1);
        rd_miss(4, 9, 2, "R5");
        lock_way2 = 1'b0; lock_way3 = 1'b0;

        // R6 write-back write hit
        rd_miss(1, 20, 0, "R6");
        op(1'b1, A(1, 20, 1), 32'hDEAD_0001, "R6", 1'b1);
        op(1'b0, A(1, 20, 1), 32'h0, "R6", 1'b1);

        // R7 dirty line is copied back before the fill
        rd_miss(2, 20, 0, "R7");
        rd_miss(3, 20, 0, "R7");
        rd_miss(4, 20, 0, "R7");
        exp_evict(A(1, 20, 0));
        exp_fill(A(5, 20, 0));
        op(1'b0, A(5, 20, 0), 32'h0, "R7", 1'b0);
        rd_miss(1, 20, 1, "R7");

        // R8 write-back write miss allocates without a memory write
        exp_fill(A(1, 30, 0));
        op(1'b1, A(1, 30, 2), 32'hBEEF_0002, "R8", 1'b0);
        op(1'b0, A(1, 30, 2), 32'h0, "R8", 1'b1);

        // R9 write-through
        wb_mode = 1'b0;
        rd_miss(1, 40, 0, "R9");
        exp_wt(A(1, 40, 0), 32'h1111_0003);
        op(1'b1, A(1, 40, 0), 32'h1111_0003, "R9", 1'b0);
        op(1'b0, A(1, 40, 0), 32'h0, "R9", 1'b1);
        exp_wt(A(2, 40, 0), 32'h2222_0004);
        op(1'b1, A(2, 40, 0), 32'h2222_0004, "R9", 1'b0);
        rd_miss(2, 40, 0, "R9");
        rd_miss(3, 40, 0, "R9");
        rd_miss(4, 40, 0, "R9");
        wb_mode = 1'b1;
        rd_miss(5, 40, 0, "R9");

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule